// File: doc/BRIEF.md
# DMA Channel Trigger and Completion Interrupt Controller

This block keeps the start and completion state for a set of DMA channels. The transfer engine sits outside it. A channel can be started in three ways. A peripheral event pulse is latched and only counts while that channel's event-enable bit is set. Software can write a one-shot start request. A finished transfer of another channel can also start it. A fixed-priority selector offers one start at a time to the transfer engine. The lowest-numbered requesting channel goes first. When the engine accepts a start, every start flag of that channel is cleared.

The engine reports each completion with a completion code and four option bits. Two of the option bits are for the last completion of a transfer and two are for intermediate completions. Depending on these bits, the code selects an interrupt-pending bit to set, a channel to start, or both. This lets channels start each other with no processor involvement. Pending bits are masked by an interrupt-enable register and ORed into one interrupt line. Software reads the pending vector to find which transfer finished, then writes ones to clear it. A start request that arrives while the same start flag is still set cannot be stored. It sets a sticky missed flag for that channel instead.

Top module: `dma_trig_irq`

## Requirements
- R1: After reset, all start flags, the event-enable and interrupt-enable registers, the pending vector and the missed vector are zero, so `startValid` and `irq` are low.
- R2: A pulse on `periphEvt[i]` latches an event flag for channel i. That flag requests a start only while bit i of the event-enable register (address 0, written with the whole value) is 1. A flag latched while the bit is 0 starts the channel once the bit is set.
- R3: A write to address 1 sets the software start flag of every channel whose data bit is 1.
- R4: `startChan` shows the lowest-numbered channel with an active request. `startValid` is low when there is none. In a cycle with `startValid` and `startReady` both high, the event, software and chain flags of that channel are all cleared.
- R5: On `cmplValid`, bit `cmplCode` of the pending vector is set if `cmplFinal` and `cmplIntEn` are both 1, or if `cmplFinal` is 0 and `cmplMidIntEn` is 1.
- R6: On `cmplValid`, the chain start flag of channel `cmplCode` is set if `cmplFinal` and `cmplChainEn` are both 1, or if `cmplFinal` is 0 and `cmplMidChainEn` is 1. A chain start sets no pending bit by itself.
- R7: `irq` is high exactly when some pending bit is set whose bit in the interrupt-enable register (address 2, written with the whole value) is also 1.
- R8: A write to address 3 clears every pending bit whose data bit is 1. If a completion sets the same bit in the same cycle, the bit stays set.
- R9: A start request on a source whose flag for that channel is already set, and is not being cleared by an accepted start in the same cycle, sets bit i of the missed vector. A write to address 4 clears the missed bits whose data bit is 1.
- R10: Writes to addresses 5 to 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periphEvt | input | NUM_CH | Peripheral event pulses, one per channel |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | NUM_CH | Register write data, one bit per channel |
| cmplValid | input | 1 | Completion report valid |
| cmplFinal | input | 1 | Report is the last completion of the transfer |
| cmplCode | input | CODE_W | Completion code: pending bit index and chain target |
| cmplIntEn | input | 1 | Interrupt on final completion |
| cmplChainEn | input | 1 | Chain on final completion |
| cmplMidIntEn | input | 1 | Interrupt on intermediate completion |
| cmplMidChainEn | input | 1 | Chain on intermediate completion |
| startReady | input | 1 | Transfer engine accepts the offered start |
| startValid | output | 1 | A channel start is offered |
| startChan | output | CODE_W | Channel number of the offered start |
| pendingVec | output | NUM_CH | Interrupt-pending vector |
| missVec | output | NUM_CH | Sticky missed-start vector |
| irq | output | 1 | Aggregated interrupt |

## Verification
Every flag and register sits directly behind a port with no more than combinational logic in between. A wrong start flag therefore shows on `startValid`/`startChan` in the first cycle after the write, event or completion that set it. A flag that is not cleared shows the cycle after an accept, as the same channel offered again. A wrong pending or enable bit shows on `pendingVec` or `irq` one cycle after the report or write. Lost or spurious missed flags show on `missVec` in the same way. The checks therefore sample one cycle after each stimulus, so any stale state is seen before the next stimulus can hide it.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;

  // Register addresses of the write interface
  typedef enum logic [2:0] {
    ADDR_EVT_EN   = 3'd0,
    ADDR_SW_SET   = 3'd1,
    ADDR_INT_EN   = 3'd2,
    ADDR_INT_CLR  = 3'd3,
    ADDR_MISS_CLR = 3'd4
  } regAddr_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic evtEnWr;
    logic swSetWr;
    logic intEnWr;
    logic intClrWr;
    logic missClrWr;
    logic pendSet;
    logic chainSet;
  } trigStrobe_t;

endpackage

// File: rtl/dma_trig_pick.sv
module dma_trig_pick #(
  parameter int NUM_CH = 8,
  localparam int CODE_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] reqVec,
  output logic [NUM_CH-1:0] grantVec,
  output logic [CODE_W-1:0] grantIdx,
  output logic              anyReq
);
  logic [NUM_CH:0] lowerAny;

  assign lowerAny[0] = 1'b0;

  for (genvar i = 0; i < NUM_CH; i++) begin : gPrefix
    assign lowerAny[i+1] = lowerAny[i] | reqVec[i];
    assign grantVec[i]   = reqVec[i] & ~lowerAny[i];
  end

  assign anyReq = lowerAny[NUM_CH];

  always_comb begin
    grantIdx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (grantVec[i]) grantIdx = grantIdx | CODE_W'(i);
    end
  end
endmodule

// File: rtl/dma_trig_ctrl.sv
module dma_trig_ctrl
  import dma_trig_pkg::*;
(
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic        cmplValid,
  input  logic        cmplFinal,
  input  logic        cmplIntEn,
  input  logic        cmplChainEn,
  input  logic        cmplMidIntEn,
  input  logic        cmplMidChainEn,
  output trigStrobe_t strb
);
  logic wantInt;
  logic wantChain;

  assign wantInt   = cmplFinal ? cmplIntEn   : cmplMidIntEn;
  assign wantChain = cmplFinal ? cmplChainEn : cmplMidChainEn;

  always_comb begin
    strb = '0;
    if (regWrEn) begin
      case (regAddr_e'(regAddr))
        ADDR_EVT_EN:   strb.evtEnWr   = 1'b1;
        ADDR_SW_SET:   strb.swSetWr   = 1'b1;
        ADDR_INT_EN:   strb.intEnWr   = 1'b1;
        ADDR_INT_CLR:  strb.intClrWr  = 1'b1;
        ADDR_MISS_CLR: strb.missClrWr = 1'b1;
        default: ;
      endcase
    end
    strb.pendSet  = cmplValid & wantInt;
    strb.chainSet = cmplValid & wantChain;
  end
endmodule

// File: rtl/dma_trig_dp.sv
module dma_trig_dp
  import dma_trig_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CODE_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  trigStrobe_t       strb,
  input  logic [NUM_CH-1:0] wrData,
  input  logic [CODE_W-1:0] code,
  input  logic [NUM_CH-1:0] periphEvt,
  input  logic              startReady,
  output logic              startValid,
  output logic [CODE_W-1:0] startChan,
  output logic [NUM_CH-1:0] pendingVec,
  output logic [NUM_CH-1:0] missVec,
  output logic              irq
);
  logic [NUM_CH-1:0] evtFlag, swFlag, chainFlag;
  logic [NUM_CH-1:0] evtEn, intEn, pend, missed;
  logic [NUM_CH-1:0] reqVec, grantVec, acceptMask;
  logic [NUM_CH-1:0] codeHot, swArr, chainArr, pendArr;
  logic [NUM_CH-1:0] intClrMask, missClrMask, missNew;
  logic              anyReq;

  dma_trig_pick #(.NUM_CH(NUM_CH)) u_pick (
    .reqVec  (reqVec),
    .grantVec(grantVec),
    .grantIdx(startChan),
    .anyReq  (anyReq)
  );

  assign reqVec      = (evtFlag & evtEn) | swFlag | chainFlag;
  assign startValid  = anyReq;
  assign acceptMask  = (anyReq && startReady) ? grantVec : '0;

  assign codeHot     = NUM_CH'(1) << code;
  assign swArr       = strb.swSetWr   ? wrData  : '0;
  assign chainArr    = strb.chainSet  ? codeHot : '0;
  assign pendArr     = strb.pendSet   ? codeHot : '0;
  assign intClrMask  = strb.intClrWr  ? wrData  : '0;
  assign missClrMask = strb.missClrWr ? wrData  : '0;

  assign missNew = ((periphEvt & evtFlag) | (swArr & swFlag) | (chainArr & chainFlag))
                   & ~acceptMask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evtFlag   <= '0;
      swFlag    <= '0;
      chainFlag <= '0;
      evtEn     <= '0;
      intEn     <= '0;
      pend      <= '0;
      missed    <= '0;
    end else begin
      evtFlag   <= (evtFlag   & ~acceptMask) | periphEvt;
      swFlag    <= (swFlag    & ~acceptMask) | swArr;
      chainFlag <= (chainFlag & ~acceptMask) | chainArr;
      pend      <= (pend & ~intClrMask) | pendArr;
      missed    <= (missed & ~missClrMask) | missNew;
      if (strb.evtEnWr) evtEn <= wrData;
      if (strb.intEnWr) intEn <= wrData;
    end
  end

  assign pendingVec = pend;
  assign missVec    = missed;
  assign irq        = |(pend & intEn);
endmodule

// File: rtl/dma_trig_irq.sv
module dma_trig_irq
  import dma_trig_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CODE_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] periphEvt,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [NUM_CH-1:0] regWrData,
  input  logic              cmplValid,
  input  logic              cmplFinal,
  input  logic [CODE_W-1:0] cmplCode,
  input  logic              cmplIntEn,
  input  logic              cmplChainEn,
  input  logic              cmplMidIntEn,
  input  logic              cmplMidChainEn,
  input  logic              startReady,
  output logic              startValid,
  output logic [CODE_W-1:0] startChan,
  output logic [NUM_CH-1:0] pendingVec,
  output logic [NUM_CH-1:0] missVec,
  output logic              irq
);
  trigStrobe_t strb;

  dma_trig_ctrl u_ctrl (
    .regWrEn       (regWrEn),
    .regAddr       (regAddr),
    .cmplValid     (cmplValid),
    .cmplFinal     (cmplFinal),
    .cmplIntEn     (cmplIntEn),
    .cmplChainEn   (cmplChainEn),
    .cmplMidIntEn  (cmplMidIntEn),
    .cmplMidChainEn(cmplMidChainEn),
    .strb          (strb)
  );

  dma_trig_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .wrData    (regWrData),
    .code      (cmplCode),
    .periphEvt (periphEvt),
    .startReady(startReady),
    .startValid(startValid),
    .startChan (startChan),
    .pendingVec(pendingVec),
    .missVec   (missVec),
    .irq       (irq)
  );
endmodule

// File: rtl/dma_trig_irq_chk.sv
module dma_trig_irq_chk #(
  parameter int NUM_CH = 8,
  localparam int CODE_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              regWrEn,
  input logic [2:0]        regAddr,
  input logic [NUM_CH-1:0] regWrData,
  input logic              cmplValid,
  input logic              cmplFinal,
  input logic [CODE_W-1:0] cmplCode,
  input logic              cmplIntEn,
  input logic              cmplChainEn,
  input logic              startReady,
  input logic              startValid,
  input logic [NUM_CH-1:0] pendingVec,
  input logic [NUM_CH-1:0] missVec,
  input logic              irq
);
  // R4: an offered start stays offered until accepted
  p_hold_offer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    startValid && !startReady |=> startValid);

  // R5: final completion with interrupt enabled sets the coded pending bit
  p_cmpl_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmplValid && cmplFinal && cmplIntEn |=> pendingVec[$past(cmplCode)]);

  // R6: final completion with chaining enabled yields an offered start
  p_chain_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmplValid && cmplFinal && cmplChainEn |=> startValid);

  // R7: interrupt needs at least one pending bit
  p_irq_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pendingVec != '0));

  // R8: a clear write without a completion empties the written bits
  p_int_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn && regAddr == 3'd3 && !cmplValid |=> (pendingVec & $past(regWrData)) == '0);

  // R9: missed bits fall only through a missed-clear write
  p_miss_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(regWrEn && regAddr == 3'd4) |=> (missVec & $past(missVec)) == $past(missVec));
endmodule

bind dma_trig_irq dma_trig_irq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .cmplValid  (cmplValid),
  .cmplFinal  (cmplFinal),
  .cmplCode   (cmplCode),
  .cmplIntEn  (cmplIntEn),
  .cmplChainEn(cmplChainEn),
  .startReady (startReady),
  .startValid (startValid),
  .pendingVec (pendingVec),
  .missVec    (missVec),
  .irq        (irq)
);

// File: tb/dma_trig_irq_tb.sv
module dma_trig_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 8;
  localparam int CODE_W = 3;

  // vector: [19:17] code, [16] final, [15] intEn, [14] chainEn, [13] midIntEn,
  // [12] midChainEn, [11:4] expected pending, [3] expected start, [2:0] expected channel
  localparam logic [19:0] VECS [8] = '{
    {3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 3'd0},
    {3'd6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 3'd6},
    {3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h08, 1'b0, 3'd0},
    {3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0},
    {3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 3'd5},
    {3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h01, 1'b1, 3'd0},
    {3'd7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 3'd0},
    {3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h10, 1'b1, 3'd4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_CH-1:0] periphEvt = '0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [NUM_CH-1:0] regWrData = '0;
  logic cmplValid = 1'b0, cmplFinal = 1'b0;
  logic [CODE_W-1:0] cmplCode = '0;
  logic cmplIntEn = 1'b0, cmplChainEn = 1'b0, cmplMidIntEn = 1'b0, cmplMidChainEn = 1'b0;
  logic startReady = 1'b0;
  logic startValid;
  logic [CODE_W-1:0] startChan;
  logic [NUM_CH-1:0] pendingVec, missVec;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_trig_irq #(.NUM_CH(NUM_CH)) u_dut (
    .clk(clk), .rst_n(rst_n), .periphEvt(periphEvt),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .cmplValid(cmplValid), .cmplFinal(cmplFinal), .cmplCode(cmplCode),
    .cmplIntEn(cmplIntEn), .cmplChainEn(cmplChainEn),
    .cmplMidIntEn(cmplMidIntEn), .cmplMidChainEn(cmplMidChainEn),
    .startReady(startReady), .startValid(startValid), .startChan(startChan),
    .pendingVec(pendingVec), .missVec(missVec), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [NUM_CH-1:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic acceptOne();
    startReady = 1'b1;
    @(negedge clk);
    startReady = 1'b0;
  endtask

  task automatic complete(input logic [2:0] c, input logic f, input logic ie,
                          input logic ce, input logic mie, input logic mce);
    cmplValid = 1'b1; cmplCode = c; cmplFinal = f;
    cmplIntEn = ie; cmplChainEn = ce; cmplMidIntEn = mie; cmplMidChainEn = mce;
    @(negedge clk);
    cmplValid = 1'b0; cmplIntEn = 1'b0; cmplChainEn = 1'b0;
    cmplMidIntEn = 1'b0; cmplMidChainEn = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 startValid", startValid, 0);
    chk("R1 irq", irq, 0);
    chk("R1 pendingVec", pendingVec, 0);
    chk("R1 missVec", missVec, 0);

    // R2 disabled event is held but not started
    periphEvt = 8'h04;
    @(negedge clk);
    periphEvt = '0;
    chk("R2 disabled event start", startValid, 0);
    writeReg(3'd0, 8'h04);
    chk("R2 enabled event start", startValid, 1);
    chk("R2 enabled event chan", startChan, 2);
    acceptOne();
    chk("R4 flag cleared on accept", startValid, 0);

    // R3 software start, R4 order
    writeReg(3'd1, 8'h30);
    chk("R3 sw start", startValid, 1);
    chk("R4 lowest first", startChan, 4);
    acceptOne();
    chk("R4 next chan", startChan, 5);
    acceptOne();
    chk("R4 drained", startValid, 0);

    // R4 mixed sources
    periphEvt = 8'h04; regWrEn = 1'b1; regAddr = 3'd1; regWrData = 8'h02;
    @(negedge clk);
    periphEvt = '0; regWrEn = 1'b0; regWrData = '0;
    chk("R4 mixed first", startChan, 1);
    acceptOne();
    chk("R4 mixed second", startChan, 2);
    chk("R4 mixed second valid", startValid, 1);
    acceptOne();
    chk("R4 mixed drained", startValid, 0);

    // R5 / R6 table
    for (int i = 0; i < 8; i++) begin
      logic [19:0] v;
      v = VECS[i];
      complete(v[19:17], v[16], v[15], v[14], v[13], v[12]);
      chk($sformatf("R5 pending vec %0d", i), pendingVec, v[11:4]);
      chk($sformatf("R6 chain valid vec %0d", i), startValid, v[3]);
      if (v[3]) begin
        chk($sformatf("R6 chain chan vec %0d", i), startChan, v[2:0]);
        acceptOne();
      end
      chk($sformatf("R7 no irq while masked vec %0d", i), irq, 0);
      writeReg(3'd3, 8'hFF);
      chk($sformatf("R8 cleared vec %0d", i), pendingVec, 0);
    end

    // R7 mask
    writeReg(3'd2, 8'h08);
    complete(3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R7 masked bit no irq", irq, 0);
    complete(3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R7 enabled bit irq", irq, 1);

    // R8 set wins over clear in same cycle
    regWrEn = 1'b1; regAddr = 3'd3; regWrData = 8'h08;
    complete(3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    regWrEn = 1'b0; regWrData = '0;
    chk("R8 set wins", pendingVec, 8'h28);
    chk("R8 irq held", irq, 1);
    writeReg(3'd3, 8'hFF);
    chk("R8 clear all", pendingVec, 0);
    chk("R8 irq low", irq, 0);

    // R9 missed start
    writeReg(3'd1, 8'h80);
    chk("R9 first request", startChan, 7);
    chk("R9 no miss yet", missVec, 0);
    writeReg(3'd1, 8'h80);
    chk("R9 miss set", missVec, 8'h80);
    writeReg(3'd4, 8'h80);
    chk("R9 miss cleared", missVec, 0);
    chk("R9 request kept", startValid, 1);
    startReady = 1'b1;
    writeReg(3'd1, 8'h80);
    startReady = 1'b0;
    chk("R9 no miss with accept", missVec, 0);
    chk("R9 re-request", startValid, 1);
    acceptOne();
    chk("R9 drained", startValid, 0);

    // R10 unused address
    writeReg(3'd5, 8'hFF);
    writeReg(3'd7, 8'hFF);
    chk("R10 no start", startValid, 0);
    chk("R10 no pending", pendingVec, 0);
    chk("R10 no miss", missVec, 0);
    complete(3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R10 enable kept", irq, 0);

    finish();
  end
endmodule